// File: doc/BRIEF.md
# Dual-Channel Edge Capture Timer

This block time-stamps signal transitions on two input pins, called channel A and channel B. A 12-bit counter advances on every clock and never stops. Whenever a synchronized channel input rises or falls, an 8-bit window of that counter is stored in a capture register that belongs to that channel and that edge direction. Four capture registers exist: A-rise, A-fall, B-rise and B-fall. A 3-bit scale setting chooses which 8 of the 12 counter bits are kept. This trades resolution for range.

Each capture register has an event flag. The flag is set by a matching edge and is cleared when software reads that capture register. The two flags of a channel, each gated by its own enable bit, drive that channel's single interrupt line. A handler therefore has to inspect both flags of the channel. In the optional keep-first mode, a capture register holds the time of the first edge until its flag is cleared. Software reaches the capture, status and setup registers through a byte-wide port. Reads are combinational, and writes and read side effects take effect at the clock edge.

Top module: `cap_timer`

## Requirements
- R1: After reset, all four capture registers, the setup register and the status register read 0, and both interrupt lines are low.
- R2: The internal 12-bit counter is cleared by reset. It then increases by one every clock and wraps from 4095 to 0.
- R3: The scale setting p selects which counter bits are stored. If p is 3 or less, bits [7:0] are stored. For p from 4 to 7, bits [p+4:p-3] are stored, so p=7 stores bits [11:4].
- R4: A rising edge on `cap_a` stores into offset 0x40 and a falling edge into 0x41. On `cap_b`, a rising edge stores into 0x42 and a falling edge into 0x43. The stored value is the counter window in the cycle the synchronized edge is seen. Register and flag update on the third rising clock edge after the pin changes.
- R5: Status at offset 0x45 is read-only. Bit 0 is the A-rise flag, bit 1 A-fall, bit 2 B-rise and bit 3 B-fall. Bits 7:4 read 0. Writes to 0x45 are ignored, and reading 0x45 clears nothing.
- R6: A read (rd_en high) of a capture register clears only that register's flag, at the clock edge that ends the read.
- R7: If a clearing read and a new matching edge fall in the same cycle, the flag stays set. Unless keep-first mode blocks the capture, the register takes the new value.
- R8: In keep-first mode (setup bit 7 = 1), a capture register is not overwritten while its flag is set. With bit 7 = 0, every matching edge overwrites it.
- R9: Setup bits 3:0 enable B-fall, B-rise, A-fall and A-rise, from bit 3 down to bit 0. `irq_a` is high exactly while an enabled A flag is set, and `irq_b` likewise for the B flags.
- R10: The setup register at offset 0x44 is read/write. Bit 7 is keep-first, bits 6:4 are the scale setting and bits 3:0 are the enables. Writes to any offset other than 0x44 change no register.
- R11: A pin that stays at a level after a transition produces exactly one capture. No further capture or flag change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_a | input | 1 | Channel A input, asynchronous |
| cap_b | input | 1 | Channel B input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (enables clear-on-read) |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_a | output | 1 | Channel A interrupt level |
| irq_b | output | 1 | Channel B interrupt level |

## Verification
The bench changes a pin just after a falling clock edge. It then lets two rising edges pass and takes its expected stamp from its own reference counter right after the second one, because that counter value is what the design latches at the third rising edge. Capture values, flags and interrupt levels are checked only after that third edge. Read side effects show one edge after the read strobe. The bench drives all inputs on falling edges and samples `rdata` a nanosecond later, so no check depends on the order of events at a rising edge.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    localparam int BUS_W  = 8;
    localparam int DATA_W = 8;
    localparam int PS_W   = 3;
    localparam int N_EV   = 4;

    localparam logic [BUS_W-1:0] OFS_CAP0 = 8'h40;
    localparam logic [BUS_W-1:0] OFS_CFG  = 8'h44;
    localparam logic [BUS_W-1:0] OFS_STAT = 8'h45;

    typedef struct packed {
        logic            keep_first;
        logic [PS_W-1:0] scale;
        logic [N_EV-1:0] irq_en;
    } setup_t;

    function automatic logic [BUS_W-1:0] status_byte(input logic [N_EV-1:0] f);
        logic [BUS_W-1:0] b;
        b = '0;
        b[N_EV-1:0] = f;
        return b;
    endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_N:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_N-1:0], pin};
    end

    assign rise =  chain_q[SYNC_N-1] & ~chain_q[SYNC_N];
    assign fall = ~chain_q[SYNC_N-1] &  chain_q[SYNC_N];
endmodule

// File: rtl/cap_window.sv
module cap_window #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PS_W-1:0]   scale,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] win
);
    localparam int SHIFT_MAX = CNT_W - DATA_W;
    localparam int PS_BASE   = (1 << PS_W) - 1 - SHIFT_MAX;

    logic [CNT_W-1:0] shifted;
    int               sh;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        sh      = (int'(scale) > PS_BASE) ? int'(scale) - PS_BASE : 0;
        shifted = cnt_q >> sh;
        win     = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/cap_slot.sv
module cap_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev,
    input  logic              clr,
    input  logic              keep_first,
    input  logic [DATA_W-1:0] win,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_q
);
    logic take;
    assign take = ev & (~keep_first | ~flag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (take) data_q <= win;
            if (ev)       flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq_a,
    output logic             irq_b
);
    localparam int N_CH = N_EV / 2;

    setup_t                       setup_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [DATA_W-1:0]            win;
    logic [N_EV-1:0]              ev;
    logic [N_EV-1:0]              clr;
    logic [N_EV-1:0]              flag_q;
    logic [N_EV-1:0][DATA_W-1:0]  cap_q;
    logic [N_CH-1:0]              pins;
    logic [N_CH-1:0]              irq;

    assign pins = {cap_b, cap_a};

    always_ff @(posedge clk) begin
        if (rst)                          setup_q <= '0;
        else if (wr_en && addr == OFS_CFG) setup_q <= setup_t'(wdata);
    end

    cap_window #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PS_W(PS_W)) u_win (
        .clk(clk), .rst(rst), .scale(setup_q.scale), .cnt_q(cnt_q), .win(win)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        cap_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
            .clk(clk), .rst(rst), .pin(pins[c]),
            .rise(ev[2*c]), .fall(ev[2*c+1])
        );
        assign irq[c] = |(flag_q[2*c +: 2] & setup_q.irq_en[2*c +: 2]);
    end

    for (genvar i = 0; i < N_EV; i++) begin : g_slot
        assign clr[i] = rd_en && (addr == OFS_CAP0 + BUS_W'(i));
        cap_slot #(.DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst(rst), .ev(ev[i]), .clr(clr[i]),
            .keep_first(setup_q.keep_first), .win(win),
            .data_q(cap_q[i]), .flag_q(flag_q[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CFG)  rdata = setup_q;
        if (addr == OFS_STAT) rdata = status_byte(flag_q);
        for (int i = 0; i < N_EV; i++)
            if (addr == OFS_CAP0 + BUS_W'(i)) rdata = cap_q[i];
    end

    assign irq_a = irq[0];
    assign irq_b = irq[1];
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      rd_en,
    input logic [BUS_W-1:0]          addr,
    input logic [BUS_W-1:0]          rdata,
    input logic                      irq_a,
    input logic                      irq_b,
    input logic [CNT_W-1:0]          cnt_q,
    input logic [N_EV-1:0]           ev,
    input logic [N_EV-1:0]           flag_q,
    input logic [N_EV-1:0][DATA_W-1:0] cap_q,
    input logic                      keep_first
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

    p_stat_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_STAT) |-> rdata[7:4] == 4'h0);

    p_irq_a_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> (|flag_q[1:0]));

    p_irq_b_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> (|flag_q[3:2]));

    p_single_dir_a_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev[1:0]));

    p_single_dir_b_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev[3:2]));

    for (genvar i = 0; i < N_EV; i++) begin : g_p
        p_flag_on_event_r4: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> flag_q[i]);

        p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (rd_en && addr == OFS_CAP0 + BUS_W'(i) && !ev[i]) |=> !flag_q[i]);

        p_keep_first_r8: assert property (@(posedge clk) disable iff (rst)
            (keep_first && flag_q[i]) |=> cap_q[i] == $past(cap_q[i]));
    end
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .irq_a(irq_a), .irq_b(irq_b), .cnt_q(cnt_q), .ev(ev), .flag_q(flag_q),
    .cap_q(cap_q), .keep_first(setup_q.keep_first)
);

// File: tb/test_cap_timer.sv
`timescale 1ns/1ps
module test_cap_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_a = 1'b0, cap_b = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_a, irq_b;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;
    logic [11:0] ref_cnt;
    int  cur_ps = 0;

    cap_timer i_cap_timer (
        .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    always #2 clk = ~clk;

    // reference timebase per R2
    always @(posedge clk) begin
        if (rst) ref_cnt <= 12'd0;
        else     ref_cnt <= ref_cnt + 12'd1;
    end

    function automatic logic [7:0] window_of(input logic [11:0] c, input int p);
        int sh;
        sh = (p > 3) ? p - 3 : 0;
        return 8'((c >> sh) & 12'hFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (a == 8'h44) cur_ps = int'(d[6:4]);
    endtask

    task automatic drive(input int ch, input logic v, output logic [7:0] exp);
        @(negedge clk);
        if (ch == 0) cap_a = v; else cap_b = v;
        @(posedge clk);
        @(posedge clk);
        #1 exp = window_of(ref_cnt, cur_ps);
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        for (int i = 0; i < 4; i++) rd(8'h40 + 8'(i), d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int i = 0; i < 6; i++) begin
            peek(8'h40 + 8'(i), d);
            chk("R1 reset value", d, 0);
        end
        chk("R1 irq low", {irq_b, irq_a}, 0);
    endtask

    task automatic t_setup();
        logic [7:0] d;
        wr(8'h44, 8'hA5);
        peek(8'h44, d); chk("R10 setup readback", d, 8'hA5);
        wr(8'h46, 8'h5A);
        peek(8'h44, d); chk("R10 foreign write ignored", d, 8'hA5);
        wr(8'h45, 8'hFF);
        peek(8'h45, d); chk("R5 status write ignored", d, 8'h00);
        wr(8'h40, 8'hFF);
        peek(8'h40, d); chk("R10 capture reg write ignored", d, 8'h00);
        wr(8'h44, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] e0, e1, e2, e3, d;
        drive(0, 1'b1, e0);
        peek(8'h40, d); chk("R4 A rise stamp", d, e0);
        peek(8'h45, d); chk("R5 status after A rise", d, 8'h01);
        drive(0, 1'b0, e1);
        peek(8'h41, d); chk("R4 A fall stamp", d, e1);
        drive(1, 1'b1, e2);
        peek(8'h42, d); chk("R4 B rise stamp", d, e2);
        drive(1, 1'b0, e3);
        peek(8'h43, d); chk("R4 B fall stamp", d, e3);
        peek(8'h45, d); chk("R5 all flags", d, 8'h0F);
        repeat (6) @(posedge clk);
        peek(8'h40, d); chk("R11 level held, no new capture", d, e0);
        peek(8'h43, d); chk("R11 B level held", d, e3);
        // status read clears nothing (R5), data read clears its own flag (R6)
        rd(8'h45, d);
        peek(8'h45, d); chk("R5 status read clears nothing", d, 8'h0F);
        rd(8'h41, d);
        peek(8'h45, d); chk("R6 clear only A fall", d, 8'h0D);
        clear_all();
        peek(8'h45, d); chk("R6 all cleared", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] e, d;
        wr(8'h44, 8'h02);
        drive(0, 1'b1, e);
        chk("R9 disabled flag no irq", {irq_b, irq_a}, 2'b00);
        drive(0, 1'b0, e);
        chk("R9 A fall enabled irq", {irq_b, irq_a}, 2'b01);
        rd(8'h41, d);
        #1 chk("R9 irq drops after clear", {irq_b, irq_a}, 2'b00);
        wr(8'h44, 8'h0C);
        drive(1, 1'b1, e);
        chk("R9 B rise irq", {irq_b, irq_a}, 2'b10);
        rd(8'h42, d);
        #1 chk("R9 B irq drops", {irq_b, irq_a}, 2'b00);
        drive(1, 1'b0, e);
        chk("R9 B fall irq", {irq_b, irq_a}, 2'b10);
        wr(8'h44, 8'h00);
        clear_all();
    endtask

    task automatic t_scale();
        logic [7:0] e, d;
        int plist[5] = '{0, 2, 4, 6, 7};
        foreach (plist[k]) begin
            wr(8'h44, 8'(plist[k] << 4));
            repeat (37 * (k + 1)) @(posedge clk);
            drive(0, 1'b1, e);
            peek(8'h40, d); chk($sformatf("R3 scale %0d", plist[k]), d, e);
            drive(0, 1'b0, e);
            peek(8'h41, d); chk($sformatf("R3 scale %0d fall", plist[k]), d, e);
            clear_all();
        end
        wr(8'h44, 8'h00);
    endtask

    task automatic t_keep();
        logic [7:0] e1, e2, d;
        wr(8'h44, 8'h80);
        drive(0, 1'b1, e1);
        drive(0, 1'b0, e2);
        repeat (5) @(posedge clk);
        drive(0, 1'b1, e2);
        peek(8'h40, d); chk("R8 keep first edge", d, e1);
        wr(8'h44, 8'h00);
        drive(0, 1'b0, e2);
        repeat (5) @(posedge clk);
        drive(0, 1'b1, e2);
        peek(8'h40, d); chk("R8 overwrite when keep off", d, e2);
        clear_all();
    endtask

    task automatic t_collide();
        logic [7:0] e, d;
        drive(0, 1'b0, e);
        clear_all();
        drive(0, 1'b1, e);
        drive(0, 1'b0, e);
        @(negedge clk);
        cap_a = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 e = window_of(ref_cnt, cur_ps);
        addr = 8'h40; rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
        peek(8'h45, d); chk("R7 event beats clear", d, 8'h03);
        peek(8'h40, d); chk("R7 new stamp stored", d, e);
        clear_all();
    endtask

    task automatic t_wrap();
        logic [7:0] e, d;
        wr(8'h44, 8'h70);
        while (ref_cnt < 12'hFF0) @(posedge clk);
        repeat (20) @(posedge clk);
        drive(1, 1'b1, e);
        peek(8'h42, d); chk("R2 counter after wrap", d, e);
        chk("R2 wrapped expectation small", (e < 8'h10), 1);
        clear_all();
        wr(8'h44, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_setup();
        t_basic();
        t_irq();
        t_scale();
        t_keep();
        t_collide();
        t_wrap();
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule